// File: doc/BRIEF.md
# Branch Target and PC Update Unit

This unit works out where execution goes after a flow-control instruction. It takes the program counter, the code segment, a three-bit flow mode, a taken flag, the 16-bit word that follows the opcode and the 8-bit byte that selects a segment. It then returns a new program counter and segment together on a single load strobe. Condition evaluation, decode and instruction fetch happen elsewhere. The program counter supplied with a request is the fall-through address: the address just past the instruction's post-word.

Requests enter on a valid/ready handshake. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. The sender must hold every `req_*` field stable while `req_valid` is high and `req_ready` is low. Direct modes finish one cycle after they are accepted, so `req_ready` stays high and a request may arrive every cycle.

The indirect mode fetches its target from memory through a read port. The address phase uses `mem_req_valid`/`mem_req_ready`, and the unit holds the address until the port accepts it. The data phase is a single-cycle `mem_rsp_valid` pulse that the unit cannot stall. While the read is outstanding, `req_ready` is low.

Top module: `branch_pc_unit`

## Requirements
- R1: After reset, `upd_load` and `mem_req_valid` are 0, `upd_pc` and `upd_cs` are 0, and `req_ready` is 1.
- R2: `req_ready` is low from the cycle after an indirect request is accepted until the cycle its load strobe is high. `upd_load` is never high while `req_ready` is low.
- R3: Mode code 0 (skip) with take=1 loads PC = fall-through + 2 modulo 2^16 and keeps the segment.
- R4: Mode code 1 (absolute) with take=1 loads PC = post-word and keeps the segment.
- R5: Mode code 2 (far) with take=1 loads the segment from the post-byte and PC from the post-word, on the same strobe.
- R6: Mode code 3 (relative) with take=1 loads PC = fall-through + post-word, where the post-word is signed 16-bit and the sum wraps modulo 2^16. The segment is kept.
- R7: Mode code 4 (indirect) with take=1 raises `mem_req_valid` with `mem_req_addr` = post-word and holds both stable until `mem_req_ready`. One cycle after `mem_rsp_valid` it loads PC = `mem_rsp_data` and keeps the segment.
- R8: With take=0, any mode loads PC = fall-through and keeps the segment, and no memory read is issued.
- R9: Mode codes 5, 6 and 7 behave as not taken, whatever `req_take` is.
- R10: A non-memory request gives exactly one `upd_load` pulse, in the cycle after acceptance. `upd_pc`/`upd_cs` hold their values between pulses.
- R11: A `mem_rsp_valid` pulse while no read is outstanding has no effect on `upd_load`, `upd_pc` or `upd_cs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_mode | input | 3 | Flow mode code |
| req_take | input | 1 | Branch taken |
| req_pc | input | 16 | Fall-through PC (just past post-word) |
| req_cs | input | 8 | Current code segment |
| req_pword | input | 16 | Instruction post-word |
| req_pbyte | input | 8 | Instruction post-byte |
| mem_req_valid | output | 1 | Indirect read address valid |
| mem_req_ready | input | 1 | Memory accepts address |
| mem_req_addr | output | 16 | Indirect read address |
| mem_rsp_valid | input | 1 | Read data valid (one-cycle pulse) |
| mem_rsp_data | input | 16 | Read data |
| upd_load | output | 1 | Commit strobe for new PC and CS |
| upd_pc | output | 16 | New program counter |
| upd_cs | output | 8 | New code segment |

## Verification
The assertions assume a few things about the environment:
- The request fields stay stable while a request waits.
- `mem_rsp_valid` arrives only after the address handshake.
- Read data is valid in the cycle of `mem_rsp_valid`.

The bench respects each of these:
- It drives each request for exactly one accepting edge.
- It raises the response no earlier than the cycle after `mem_req_ready`.
- It pulses a stray response only while the unit is idle.

The sweep covers all eight mode codes, both take values and four operand sets, including wrap at 0xFFFF and a negative offset. Indirect reads use varied address-stall and response delays.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  localparam int PC_W   = 16;
  localparam int CS_W   = 8;
  localparam int MODE_W = 3;
  localparam int SKIP_WORDS = 2;

  typedef enum logic [MODE_W-1:0] {
    FM_SKIP = 3'd0,
    FM_ABS  = 3'd1,
    FM_FAR  = 3'd2,
    FM_REL  = 3'd3,
    FM_IND  = 3'd4
  } flow_mode_e;
endpackage

// File: rtl/bpu_target_calc.sv
module bpu_target_calc
  import bpu_pkg::*;
#(
  parameter int PW = PC_W,
  parameter int CW = CS_W,
  parameter int SKIP = SKIP_WORDS
) (
  input  logic [MODE_W-1:0] mode,
  input  logic              take,
  input  logic [PW-1:0]     pc,
  input  logic [CW-1:0]     cs,
  input  logic [PW-1:0]     pword,
  input  logic [CW-1:0]     pbyte,
  output logic [PW-1:0]     tgt_pc,
  output logic [CW-1:0]     tgt_cs,
  output logic              use_mem
);
  localparam logic [PW-1:0] SKIP_INC = PW'(SKIP);

  always_comb begin
    tgt_pc  = pc;
    tgt_cs  = cs;
    use_mem = 1'b0;
    if (take) begin
      case (mode)
        FM_SKIP: tgt_pc = pc + SKIP_INC;
        FM_ABS:  tgt_pc = pword;
        FM_FAR: begin
          tgt_pc = pword;
          tgt_cs = pbyte;
        end
        FM_REL:  tgt_pc = pc + pword;
        FM_IND:  use_mem = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bpu_mem_fetch.sv
module bpu_mem_fetch
  import bpu_pkg::*;
#(
  parameter int PW = PC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [PW-1:0] start_addr,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [PW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [PW-1:0] mem_rsp_data,
  output logic          done,
  output logic [PW-1:0] done_data
);
  typedef enum logic [1:0] {FS_IDLE, FS_ADDR, FS_DATA} fetch_st_e;
  fetch_st_e st;
  logic [PW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= FS_IDLE;
      addr_q <= '0;
    end else begin
      case (st)
        FS_IDLE: if (start) begin
          st     <= FS_ADDR;
          addr_q <= start_addr;
        end
        FS_ADDR: if (mem_req_ready) st <= FS_DATA;
        FS_DATA: if (mem_rsp_valid) st <= FS_IDLE;
        default: st <= FS_IDLE;
      endcase
    end
  end

  assign busy          = (st != FS_IDLE);
  assign mem_req_valid = (st == FS_ADDR);
  assign mem_req_addr  = addr_q;
  assign done          = (st == FS_DATA) && mem_rsp_valid;
  assign done_data     = mem_rsp_data;

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
  AST_ADDR_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (mem_req_valid && mem_req_addr == $past(start_addr))); // R7
endmodule

// File: rtl/branch_pc_unit.sv
module branch_pc_unit
  import bpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic              req_take,
  input  logic [PC_W-1:0]   req_pc,
  input  logic [CS_W-1:0]   req_cs,
  input  logic [PC_W-1:0]   req_pword,
  input  logic [CS_W-1:0]   req_pbyte,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PC_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PC_W-1:0]   mem_rsp_data,
  output logic              upd_load,
  output logic [PC_W-1:0]   upd_pc,
  output logic [CS_W-1:0]   upd_cs
);
  logic [PC_W-1:0] tgt_pc;
  logic [CS_W-1:0] tgt_cs;
  logic            use_mem;
  logic            fetch_busy;
  logic            fetch_done;
  logic [PC_W-1:0] fetch_data;
  logic [CS_W-1:0] hold_cs;
  logic            accept;

  bpu_target_calc #(.PW(PC_W), .CW(CS_W), .SKIP(SKIP_WORDS)) u_calc (
    .mode(req_mode), .take(req_take), .pc(req_pc), .cs(req_cs),
    .pword(req_pword), .pbyte(req_pbyte),
    .tgt_pc(tgt_pc), .tgt_cs(tgt_cs), .use_mem(use_mem)
  );

  assign req_ready = !fetch_busy;
  assign accept    = req_valid && req_ready;

  bpu_mem_fetch #(.PW(PC_W)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .start(accept && use_mem), .start_addr(req_pword),
    .busy(fetch_busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(fetch_done), .done_data(fetch_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_load <= 1'b0;
      upd_pc   <= '0;
      upd_cs   <= '0;
      hold_cs  <= '0;
    end else begin
      upd_load <= (accept && !use_mem) || fetch_done;
      if (accept && use_mem) hold_cs <= req_cs;
      if (fetch_done) begin
        upd_pc <= fetch_data;
        upd_cs <= hold_cs;
      end else if (accept && !use_mem) begin
        upd_pc <= tgt_pc;
        upd_cs <= tgt_cs;
      end
    end
  end

  AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !use_mem) |=> upd_load); // R10
  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !upd_load); // R2
  AST_FAR_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_take && req_mode == FM_FAR) |=>
      (upd_load && upd_cs == $past(req_pbyte) && upd_pc == $past(req_pword))); // R5
  AST_NOT_TAKEN_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_take) |=>
      (upd_load && upd_pc == $past(req_pc) && upd_cs == $past(req_cs))); // R8
  AST_IND_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_busy && !mem_req_valid && mem_rsp_valid) |=>
      (upd_load && upd_pc == $past(mem_rsp_data))); // R7
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !fetch_done) |=> ($stable(upd_pc) && $stable(upd_cs) && !upd_load)); // R10
endmodule

// File: tb/branch_pc_unit_tb.sv
module branch_pc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_mode = '0;
  logic        req_take = 1'b0;
  logic [15:0] req_pc = '0;
  logic [7:0]  req_cs = '0;
  logic [15:0] req_pword = '0;
  logic [7:0]  req_pbyte = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        upd_load;
  logic [15:0] upd_pc;
  logic [7:0]  upd_cs;

  int n_cmp = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_pc_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_take(req_take), .req_pc(req_pc), .req_cs(req_cs),
    .req_pword(req_pword), .req_pbyte(req_pbyte),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .upd_load(upd_load), .upd_pc(upd_pc), .upd_cs(upd_cs)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    return (a ^ 16'hA5C3) + 16'h0101;
  endfunction

  task automatic run_req(input logic [2:0] m, input logic t, input logic [15:0] pc,
                         input logic [7:0] cs, input logic [15:0] pw, input logic [7:0] pb,
                         input int rdy_dly, input int rsp_dly);
    logic [15:0] e_pc;
    logic [7:0]  e_cs;
    string tag;
    bit ind;
    e_pc = pc; e_cs = cs; ind = 1'b0; tag = "R8";
    if (!t) tag = "R8";
    else case (m)
      3'd0: begin e_pc = pc + 16'd2; tag = "R3"; end
      3'd1: begin e_pc = pw; tag = "R4"; end
      3'd2: begin e_pc = pw; e_cs = pb; tag = "R5"; end
      3'd3: begin e_pc = pc + pw; tag = "R6"; end
      3'd4: begin e_pc = mem_word(pw); ind = 1'b1; tag = "R7"; end
      default: tag = "R9";
    endcase
    @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready idle", 32'(req_ready), 1);
    req_valid = 1'b1; req_mode = m; req_take = t; req_pc = pc; req_cs = cs;
    req_pword = pw; req_pbyte = pb;
    @(negedge clk);
    req_valid = 1'b0;
    if (ind) begin
      chk(mem_req_valid && mem_req_addr == pw, "R7 addr", 32'(mem_req_addr), 32'(pw));
      for (int i = 0; i < rdy_dly; i++) begin
        chk(mem_req_valid && mem_req_addr == pw && !upd_load, "R7 hold", 32'(mem_req_addr), 32'(pw));
        chk(req_ready == 1'b0, "R2 busy", 32'(req_ready), 0);
        @(negedge clk);
      end
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      for (int i = 1; i < rsp_dly; i++) begin
        chk(!upd_load && !req_ready, "R2 wait", 32'(upd_load), 0);
        @(negedge clk);
      end
      mem_rsp_valid = 1'b1; mem_rsp_data = e_pc;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = 16'hDEAD;
    end else begin
      chk(!mem_req_valid, "R8 no read", 32'(mem_req_valid), 0);
    end
    chk(upd_load == 1'b1, {tag, " load"}, 32'(upd_load), 1);
    chk(upd_pc == e_pc, {tag, " pc"}, 32'(upd_pc), 32'(e_pc));
    chk(upd_cs == e_cs, {tag, " cs"}, 32'(upd_cs), 32'(e_cs));
    @(negedge clk);
    chk(!upd_load && upd_pc == e_pc && upd_cs == e_cs, "R10 single pulse/hold",
        32'({upd_load, upd_pc}), 32'({1'b0, e_pc}));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] pcs [4] = '{16'h1000, 16'hFFFF, 16'h0003, 16'h8000};
    logic [15:0] pws [4] = '{16'h0234, 16'h0010, 16'hFFF0, 16'h7FFF};
    logic [7:0]  pbs [4] = '{8'h05, 8'hFE, 8'h80, 8'h3C};
    logic [7:0]  css [4] = '{8'h11, 8'h00, 8'hFF, 8'h42};
    logic [15:0] keep_pc;
    logic [7:0]  keep_cs;
    repeat (3) @(negedge clk);
    chk(!upd_load && !mem_req_valid && req_ready && upd_pc == 0 && upd_cs == 0,
        "R1 reset", 32'({upd_load, mem_req_valid, req_ready}), 32'b001);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 8; m++)
      for (int t = 0; t < 2; t++)
        for (int k = 0; k < 4; k++)
          run_req(3'(m), 1'(t), pcs[k], css[k], pws[k], pbs[k], k % 3, (k % 3) + 1);
    // R11: stray response while idle
    keep_pc = upd_pc; keep_cs = upd_cs;
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 16'h5A5A;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk(!upd_load && upd_pc == keep_pc && upd_cs == keep_cs, "R11 stray rsp",
        32'({upd_load, upd_pc}), 32'({1'b0, keep_pc}));
    @(negedge clk);
    chk(!upd_load && upd_pc == keep_pc, "R11 stray rsp later", 32'(upd_pc), 32'(keep_pc));
    finish_run();
  end
endmodule